// File: doc/BRIEF.md
# Predictive Instruction Line Prefetcher

This block sits between a processor's instruction and data read ports and a slow flash read port that returns a whole 128-bit line after a number of wait states. It holds the line the processor is currently running from in one slot and a speculatively read next line in a second slot. Whenever the processor fetches from a line that is already held, the block starts a flash read of the next sequential 16-byte line. Straight-line code can then find its next line waiting in the prefetch slot.

A fetch that matches neither slot goes to flash. Any speculative read that is still in progress is dropped at once in favour of the requested line, so a jump costs no more than it would with no prediction. A data read always takes the flash port: it aborts any instruction read in flight, and prediction stays idle until a later fetch hits a held line. For fetches marked cacheable, the block tells a neighbouring line cache to install each line it hands over, either from the prefetch slot or straight from flash. For non-cacheable fetches it asks the cache for nothing. A cacheable fetch that the cache reports as a hit is left to the cache.

Top module: `line_prefetcher`

## Requirements
- R1: After reset, `if_ready`, `dr_ready`, `fl_start` and `fill_valid` are low, and no flash read is started until the first instruction fetch arrives.
- R2: A fetch whose line is in neither slot starts a flash read of that line in the same cycle. The fetch completes in the cycle `fl_ready` returns, and `if_rdata` is the word chosen by the two lowest bits of `if_waddr` (word k sits at bits 32k+31..32k of the line).
- R3: A fetch whose line is in the current slot or the prefetch slot completes in the cycle it is presented, with the addressed word.
- R4: While `pf_enable` is 1, a fetch served from a slot starts a flash read of the next line (line address plus one) in that cycle. This does not happen if that line is already held or already being read.
- R5: A fetch for a line other than the one being speculatively read starts a new flash read of its own line in the same cycle. Its latency is the same as in R2.
- R6: A cacheable fetch served from the prefetch slot or from a flash return raises `fill_valid` for that cycle, with `fill_tag` equal to the fetch's line address and `fill_line` the line. A fetch served from the current slot raises no fill.
- R7: A non-cacheable fetch never raises `fill_valid`, whether it is served from a slot or from flash.
- R8: A new data read starts a flash read of its line in the cycle it is raised, aborting any instruction read in flight. `dr_ready` rises in the cycle that read returns, with the addressed word on `dr_rdata`.
- R9: A speculative read aborted by a data read is not restarted. No flash read starts while the processor is idle, and the next fetch of the predicted line is a full miss. Prediction resumes at the next slot hit.
- R10: A cacheable fetch with `cache_hit` high gets no `if_ready`, no fill and no flash read from the block.
- R11: While `pf_enable` is 0, no speculative read is started. The next sequential line is then read only on demand, with the latency of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_enable | input | 1 | 1 enables next-line prediction |
| if_req | input | 1 | Instruction fetch request, held until if_ready |
| if_waddr | input | 30 | Fetch word address (byte address bits 31..2) |
| if_cacheable | input | 1 | Fetch targets a cacheable region |
| cache_hit | input | 1 | Neighbouring cache holds the fetched line |
| if_ready | output | 1 | Fetch complete this cycle |
| if_rdata | output | 32 | Fetched instruction word |
| dr_req | input | 1 | Data read request, held until dr_ready |
| dr_waddr | input | 30 | Data read word address |
| dr_ready | output | 1 | Data read complete this cycle |
| dr_rdata | output | 32 | Data read word |
| fl_start | output | 1 | Start (or restart) a flash line read |
| fl_line | output | 28 | Line address of the flash read |
| fl_ready | input | 1 | Flash line of the latest start is valid |
| fl_rdata | input | 128 | Flash line data |
| fill_valid | output | 1 | Ask the cache to install a line in its victim way |
| fill_tag | output | 28 | Line address to install |
| fill_line | output | 128 | Line data to install |

## Verification
The bench builds the block with its default 32-bit address, 128-bit line and 32-bit word. It attaches a flash model with three wait states, so a full read takes four cycles. That window is long enough for a fetch to arrive while a speculative read is only part done, which gives a latency strictly between zero and a full miss. It is also long enough to redirect or abort a read midway. With four words per line, successive fetches within a line exercise every word lane, and hits on the current slot can be told apart from hits on the prefetch slot.

// File: rtl/lp_pkg.sv
// Shared types for the line prefetcher.
// Assumes: one outstanding flash read at a time.
package lp_pkg;
    typedef enum logic {
        FK_INSTR = 1'b0,
        FK_DATA  = 1'b1
    } fl_kind_t;
endpackage

// File: rtl/lp_line_slot.sv
// One line-holding slot: valid flag, line tag and line data, plus a tag compare.
// Assumes: a write takes priority over a clear in the same cycle.
module lp_line_slot #(
    parameter int TAG_W  = 28,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              clr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              valid,
    output logic [TAG_W-1:0]  tag,
    output logic [LINE_W-1:0] line,
    output logic              hit
);
    // Hold the slot contents; load on write, drop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
            line  <= '0;
        end else if (wr) begin
            valid <= 1'b1;
            tag   <= wr_tag;
            line  <= wr_line;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end

    // Report whether the looked-up line is held here.
    always_comb hit = valid && (tag == look_tag);
endmodule

// File: rtl/lp_word_pick.sv
// Selects one word of a line by its word index.
// Assumes: LINE_W is WORD_W times a power of two, with SEL_W index bits.
module lp_word_pick #(
    parameter int LINE_W = 128,
    parameter int WORD_W = 32,
    parameter int SEL_W  = 2
) (
    input  logic [LINE_W-1:0] line,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] word
);
    localparam int WORDS = LINE_W / WORD_W;

    logic [WORD_W-1:0] lane [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_lane
        assign lane[g] = line[g*WORD_W +: WORD_W];
    end

    // Pick the addressed lane.
    always_comb word = lane[sel];
endmodule

// File: rtl/lp_flash_track.sv
// Tracks the one flash read in flight: whether busy, what kind, and which line.
// Assumes: a new start replaces (aborts) the read in flight; fl_ready ends it.
module lp_flash_track
    import lp_pkg::*;
#(
    parameter int TAG_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  fl_kind_t         start_kind,
    input  logic [TAG_W-1:0] start_line,
    input  logic             fl_ready,
    output logic             busy,
    output fl_kind_t         kind,
    output logic [TAG_W-1:0] line
);
    // Record each start; clear busy when the read returns without a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            kind <= FK_INSTR;
            line <= '0;
        end else if (start) begin
            busy <= 1'b1;
            kind <= start_kind;
            line <= start_line;
        end else if (fl_ready) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/line_prefetcher.sv
// Predictive instruction line prefetcher between processor read ports and flash.
// Holds a current line and one prefetched next line. A slot hit predicts the
// next sequential line, a mismatch redirects the flash read at once, and a
// data read pre-empts instruction reads with no resume. Cacheable hand-overs
// are pushed to a neighbouring cache. Assumes requests are held until ready.
module line_prefetcher
    import lp_pkg::*;
#(
    parameter int  ADDR_W = 32,
    parameter int  LINE_W = 128,
    parameter int  WORD_W = 32,
    localparam int OFF_W  = $clog2(LINE_W / 8),
    localparam int BYTE_W = $clog2(WORD_W / 8),
    localparam int SEL_W  = OFF_W - BYTE_W,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int WA_W   = ADDR_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pf_enable,
    input  logic              if_req,
    input  logic [WA_W-1:0]   if_waddr,
    input  logic              if_cacheable,
    input  logic              cache_hit,
    output logic              if_ready,
    output logic [WORD_W-1:0] if_rdata,
    input  logic              dr_req,
    input  logic [WA_W-1:0]   dr_waddr,
    output logic              dr_ready,
    output logic [WORD_W-1:0] dr_rdata,
    output logic              fl_start,
    output logic [TAG_W-1:0]  fl_line,
    input  logic              fl_ready,
    input  logic [LINE_W-1:0] fl_rdata,
    output logic              fill_valid,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [LINE_W-1:0] fill_line
);
    logic [TAG_W-1:0]  req_line, next_line, dr_line;
    logic [SEL_W-1:0]  req_sel, dr_sel;
    logic              if_mine, buf_hit, promote;
    logic              cur_valid, cur_hit, pfb_valid, pfb_hit;
    logic [TAG_W-1:0]  cur_tag, pfb_tag;
    logic [LINE_W-1:0] cur_data, pfb_data, if_line_sel;
    logic              cur_wr, pfb_wr;
    logic [TAG_W-1:0]  cur_wr_tag;
    logic [LINE_W-1:0] cur_wr_line;
    logic              trk_busy, trk_instr, trk_data;
    fl_kind_t          trk_kind, start_kind;
    logic [TAG_W-1:0]  trk_line;
    logic              ret_instr, ret_match, inflight_req, next_covered;
    logic              instr_ok, go_data, go_dem, go_spec;

    // Split the word addresses into line tag and word index.
    always_comb begin
        req_line  = if_waddr[WA_W-1:SEL_W];
        req_sel   = if_waddr[SEL_W-1:0];
        dr_line   = dr_waddr[WA_W-1:SEL_W];
        dr_sel    = dr_waddr[SEL_W-1:0];
        next_line = req_line + TAG_W'(1);
    end

    lp_line_slot #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_cur (
        .clk(clk), .rst_n(rst_n), .wr(cur_wr), .clr(1'b0),
        .wr_tag(cur_wr_tag), .wr_line(cur_wr_line), .look_tag(req_line),
        .valid(cur_valid), .tag(cur_tag), .line(cur_data), .hit(cur_hit)
    );

    lp_line_slot #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_pfb (
        .clk(clk), .rst_n(rst_n), .wr(pfb_wr), .clr(promote),
        .wr_tag(trk_line), .wr_line(fl_rdata), .look_tag(req_line),
        .valid(pfb_valid), .tag(pfb_tag), .line(pfb_data), .hit(pfb_hit)
    );

    lp_flash_track #(.TAG_W(TAG_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .start(fl_start), .start_kind(start_kind),
        .start_line(fl_line), .fl_ready(fl_ready),
        .busy(trk_busy), .kind(trk_kind), .line(trk_line)
    );

    // Classify the fetch against the slots and the read in flight.
    always_comb begin
        if_mine      = if_req && !(if_cacheable && cache_hit);
        buf_hit      = if_mine && (cur_hit || pfb_hit);
        promote      = if_mine && pfb_hit && !cur_hit;
        trk_instr    = trk_busy && (trk_kind == FK_INSTR);
        trk_data     = trk_busy && (trk_kind == FK_DATA);
        ret_instr    = fl_ready && trk_instr;
        inflight_req = trk_instr && (trk_line == req_line);
        ret_match    = ret_instr && if_mine && !buf_hit && (trk_line == req_line);
        next_covered = (pfb_valid && pfb_tag == next_line) ||
                       (cur_valid && cur_tag == next_line) ||
                       (trk_instr && trk_line == next_line);
    end

    // Arbitrate the flash port: data first, then demand, then prediction.
    always_comb begin
        instr_ok   = !dr_req && !trk_data;
        go_data    = dr_req && !trk_data;
        go_dem     = instr_ok && if_mine && !buf_hit && !inflight_req;
        go_spec    = instr_ok && buf_hit && pf_enable && !next_covered;
        fl_start   = go_data || go_dem || go_spec;
        start_kind = go_data ? FK_DATA : FK_INSTR;
        if (go_data)     fl_line = dr_line;
        else if (go_dem) fl_line = req_line;
        else             fl_line = next_line;
    end

    // Route returned and promoted lines into the slots.
    always_comb begin
        cur_wr      = ret_match || promote;
        cur_wr_tag  = ret_match ? trk_line : pfb_tag;
        cur_wr_line = ret_match ? fl_rdata : pfb_data;
        pfb_wr      = ret_instr && !ret_match;
    end

    // Choose the line that serves the fetch and raise any cache fill.
    always_comb begin
        if (cur_hit)      if_line_sel = cur_data;
        else if (pfb_hit) if_line_sel = pfb_data;
        else              if_line_sel = fl_rdata;
        if_ready   = buf_hit || ret_match;
        fill_valid = if_cacheable && (promote || ret_match);
        fill_tag   = req_line;
        fill_line  = if_line_sel;
        dr_ready   = fl_ready && trk_data;
    end

    lp_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_if_pick (
        .line(if_line_sel), .sel(req_sel), .word(if_rdata)
    );

    lp_word_pick #(.LINE_W(LINE_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_dr_pick (
        .line(fl_rdata), .sel(dr_sel), .word(dr_rdata)
    );
endmodule

// File: rtl/lp_checker.sv
// Port-level properties of the line prefetcher, bound to every instance.
// Assumes: requests are held until served and the flash answers the latest start.
module lp_checker #(
    parameter int TAG_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pf_enable,
    input logic             if_req,
    input logic             if_cacheable,
    input logic             cache_hit,
    input logic             if_ready,
    input logic [TAG_W-1:0] if_line,
    input logic             fill_valid,
    input logic [TAG_W-1:0] fill_tag,
    input logic             dr_req,
    input logic [TAG_W-1:0] dr_line,
    input logic             fl_start,
    input logic [TAG_W-1:0] fl_line
);
    // R6: a fill accompanies a completed cacheable fetch of that line.
    a_r6_fill_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> (if_ready && if_cacheable && fill_tag == if_line));

    // R7: non-cacheable fetches never fill.
    a_r7_nc_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && !if_cacheable) |-> !fill_valid);

    // R8: a newly raised data read takes the flash port at once.
    a_r8_data_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dr_req) |-> (fl_start && fl_line == dr_line));

    // R10: a fetch the cache owns is left alone.
    a_r10_cache_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && if_cacheable && cache_hit) |-> (!if_ready && !fill_valid));

    // R10: no instruction read starts for a fetch the cache owns.
    a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (if_req && if_cacheable && cache_hit && !dr_req) |-> !fl_start);

    // R11: with prediction off, no read starts alongside a served fetch.
    a_r11_no_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_enable && fl_start && !dr_req) |-> !if_ready);
endmodule

bind line_prefetcher lp_checker #(.TAG_W(TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .if_req(if_req),
    .if_cacheable(if_cacheable), .cache_hit(cache_hit), .if_ready(if_ready),
    .if_line(if_waddr[WA_W-1:SEL_W]), .fill_valid(fill_valid),
    .fill_tag(fill_tag), .dr_req(dr_req), .dr_line(dr_waddr[WA_W-1:SEL_W]),
    .fl_start(fl_start), .fl_line(fl_line)
);

// File: tb/line_prefetcher_test.sv
// Bench for line_prefetcher: a fetch vector table, then directed corner tests.
module line_prefetcher_test;
    localparam int WAIT = 3;
    localparam int FULL = WAIT + 1;
    localparam int TAG_W = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_enable = 1'b1;
    logic if_req = 1'b0, if_cacheable = 1'b0, cache_hit = 1'b0;
    logic [29:0] if_waddr = '0;
    logic dr_req = 1'b0;
    logic [29:0] dr_waddr = '0;
    logic if_ready, dr_ready, fl_start, fl_ready, fill_valid;
    logic [31:0] if_rdata, dr_rdata;
    logic [TAG_W-1:0] fl_line, fill_tag;
    logic [127:0] fl_rdata, fill_line;

    int total = 0, bad = 0, n_start = 0;
    bit done = 0;

    always #4 clk = ~clk;

    line_prefetcher uut (
        .clk(clk), .rst_n(rst_n), .pf_enable(pf_enable), .if_req(if_req),
        .if_waddr(if_waddr), .if_cacheable(if_cacheable), .cache_hit(cache_hit),
        .if_ready(if_ready), .if_rdata(if_rdata), .dr_req(dr_req),
        .dr_waddr(dr_waddr), .dr_ready(dr_ready), .dr_rdata(dr_rdata),
        .fl_start(fl_start), .fl_line(fl_line), .fl_ready(fl_ready),
        .fl_rdata(fl_rdata), .fill_valid(fill_valid), .fill_tag(fill_tag),
        .fill_line(fill_line)
    );

    function automatic logic [31:0] word_of(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
    endfunction

    function automatic logic [127:0] line_data(input logic [TAG_W-1:0] ln);
        logic [127:0] d;
        for (int i = 0; i < 4; i++) d[i*32 +: 32] = word_of({ln, i[1:0], 2'b00});
        return d;
    endfunction

    // Flash model: answers the latest start after WAIT extra cycles.
    logic fm_busy = 1'b0;
    logic [2:0] fm_cnt = '0;
    logic [TAG_W-1:0] fm_line = '0;
    always @(posedge clk) begin
        if (!rst_n) fm_busy <= 1'b0;
        else if (fl_start) begin
            fm_busy <= 1'b1; fm_cnt <= 3'(WAIT); fm_line <= fl_line;
        end else if (fm_busy && fm_cnt != 0) fm_cnt <= fm_cnt - 3'd1;
        else if (fm_busy) fm_busy <= 1'b0;
    end
    assign fl_ready = fm_busy && (fm_cnt == 0);
    assign fl_rdata = line_data(fm_line);

    always @(posedge clk) if (rst_n && fl_start) n_start <= n_start + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(negedge clk); if_req = 1'b0; end
    endtask

    task automatic fetch(input logic [31:0] a, input logic c, output int lat,
                         output logic fseen, output logic [TAG_W-1:0] ftag,
                         output logic [31:0] data);
        bit got = 0;
        @(negedge clk);
        if_req = 1'b1; if_waddr = a[31:2]; if_cacheable = c; cache_hit = 1'b0;
        lat = 0; fseen = 0; ftag = '0; data = '0;
        while (!got && lat <= 40) begin
            #3;
            if (fill_valid) begin fseen = 1; ftag = fill_tag; end
            if (if_ready) begin data = if_rdata; got = 1; end
            else begin lat++; @(negedge clk); end
        end
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        cach;
        logic [3:0]  gap;
        logic [1:0]  lat;   // 0 hit, 1 full miss, 2 partial wait
        logic        fill;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0100, 1'b1, 4'd0, 2'd1, 1'b1},
        '{32'h0000_0104, 1'b1, 4'd0, 2'd0, 1'b0},
        '{32'h0000_0110, 1'b1, 4'd6, 2'd0, 1'b1},
        '{32'h0000_011C, 1'b0, 4'd0, 2'd0, 1'b0},
        '{32'h0000_0120, 1'b0, 4'd6, 2'd0, 1'b0},
        '{32'h0000_0300, 1'b0, 4'd0, 2'd1, 1'b0},
        '{32'h0000_0308, 1'b1, 4'd0, 2'd0, 1'b0},
        '{32'h0000_0314, 1'b1, 4'd0, 2'd2, 1'b1}
    };
    localparam string VTAG [NV] = '{"R2", "R3", "R4", "R3", "R7", "R5", "R3", "R6"};

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat, n0;
        logic fs;
        logic [TAG_W-1:0] ft;
        logic [31:0] d;
        bit seen;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: quiet outputs and no flash activity before the first fetch
        @(negedge clk); #3;
        chk(!if_ready, "R1 if_ready", 64'(if_ready), 0);
        chk(!dr_ready, "R1 dr_ready", 64'(dr_ready), 0);
        chk(!fl_start, "R1 fl_start", 64'(fl_start), 0);
        chk(!fill_valid, "R1 fill_valid", 64'(fill_valid), 0);
        idle(10);
        chk(n_start == 0, "R1 no early read", 64'(n_start), 0);

        for (int i = 0; i < NV; i++) begin
            idle(int'(VEC[i].gap));
            fetch(VEC[i].addr, VEC[i].cach, lat, fs, ft, d);
            chk(d == word_of(VEC[i].addr), {VTAG[i], " data"}, 64'(d),
                64'(word_of(VEC[i].addr)));
            case (VEC[i].lat)
                2'd0: chk(lat == 0, {VTAG[i], " latency"}, 64'(lat), 0);
                2'd1: chk(lat == FULL, {VTAG[i], " latency"}, 64'(lat), 64'(FULL));
                default: chk(lat > 0 && lat < FULL, {VTAG[i], " partial latency"},
                             64'(lat), 64'(FULL - 1));
            endcase
            chk(fs == VEC[i].fill, {VTAG[i], " fill"}, 64'(fs), 64'(VEC[i].fill));
            if (VEC[i].fill)
                chk(ft == VEC[i].addr[31:4], {VTAG[i], " fill_tag"}, 64'(ft),
                    64'(VEC[i].addr[31:4]));
        end

        // R10: cacheable fetch owned by the cache is ignored
        @(negedge clk);
        if_req = 1'b1; if_waddr = 30'h314 >> 2; if_cacheable = 1'b1; cache_hit = 1'b1;
        n0 = n_start; seen = 0;
        repeat (6) begin #3; if (if_ready || fill_valid) seen = 1; @(negedge clk); end
        chk(!seen, "R10 no ready or fill", 64'(seen), 0);
        chk(n_start == n0, "R10 no flash read", 64'(n_start), 64'(n0));
        if_req = 1'b0; cache_hit = 1'b0;

        // R8 / R9: data read aborts prediction, which does not resume
        fetch(32'h500, 1'b0, lat, fs, ft, d);
        fetch(32'h504, 1'b0, lat, fs, ft, d);
        @(negedge clk);
        if_req = 1'b0; dr_req = 1'b1; dr_waddr = 30'(32'h7008 >> 2);
        #3;
        chk(fl_start && fl_line == 28'h700, "R8 data start", 64'(fl_line), 64'h700);
        lat = 0;
        while (!dr_ready && lat <= 40) begin lat++; @(negedge clk); #3; end
        chk(lat == FULL, "R8 data latency", 64'(lat), 64'(FULL));
        chk(dr_rdata == word_of(32'h7008), "R8 data word", 64'(dr_rdata),
            64'(word_of(32'h7008)));
        @(negedge clk); dr_req = 1'b0;
        n0 = n_start;
        idle(10);
        chk(n_start == n0, "R9 no resume", 64'(n_start), 64'(n0));
        fetch(32'h510, 1'b0, lat, fs, ft, d);
        chk(lat == FULL, "R9 predicted line missed", 64'(lat), 64'(FULL));
        fetch(32'h514, 1'b0, lat, fs, ft, d);
        chk(lat == 0 && d == word_of(32'h514), "R3 hit word", 64'(d),
            64'(word_of(32'h514)));
        chk(fl_start && fl_line == 28'h52, "R9 R4 prediction restarts",
            64'(fl_line), 64'h52);

        // R11: prediction disabled
        @(negedge clk); if_req = 1'b0; pf_enable = 1'b0;
        fetch(32'h900, 1'b1, lat, fs, ft, d);
        chk(lat == FULL && fs, "R6 demand fill", 64'(fs), 1);
        fetch(32'h904, 1'b1, lat, fs, ft, d);
        chk(!fl_start, "R11 no start on hit", 64'(fl_start), 0);
        idle(6);
        fetch(32'h910, 1'b1, lat, fs, ft, d);
        chk(lat == FULL, "R11 next line on demand", 64'(lat), 64'(FULL));
        chk(d == word_of(32'h910), "R11 data", 64'(d), 64'(word_of(32'h910)));
        idle(2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule